// File: doc/BRIEF.md
# Flash Command and Status Emulator

This block is a clocked behavioural model of a byte-wide flash memory that can be erased one sector at a time. A host drives an asynchronous-style bus made of active-low chip select, write strobe and read strobe lines, an address and an 8-bit write data byte. The block samples that bus on the system clock. Each falling edge of the write strobe while the chip is selected counts as one bus write. A command sequencer decodes the writes and launches timed program and erase runs against a small inferred byte array.

While a run is in progress the array cannot be read. A read instead returns a status byte. Bit 7 carries the complement of the byte being programmed, or zero during an erase. Bit 6 flips on each new read. An erase can be parked so that other sectors can be read, and later resumed. A per-sector protect mask and a low-supply inhibit input block writes. The command byte values used here belong to this block: 0x40 starts a program, 0x20 starts an erase, 0xD0 confirms an erase, 0xB0 parks an erase and 0x30 resumes it.

Top module: `flash_cmd_emu`

## Requirements
- R1: After reset the array reads 0xFF everywhere, `busy` is low and the read-drive flag `dout_oe` is low.
- R2: `dout_oe` is high only when `ce_n` and `oe_n` are low and `we_n` is high. Whenever `dout_oe` is low, `dout` is 0x00.
- R3: Writing 0x40 and then writing a byte D to address A holds `busy` high for PROG_CYC+1 cycles. After that, A holds its old value AND D, so a cleared bit is never set again by programming.
- R4: While a program runs, a read returns bit 7 = NOT D[7] and bits 5:0 = 0. Bit 6 inverts between two successive reads.
- R5: Writing 0x20 and then writing 0xD0 to any address inside sector S (sector = upper log2(SECTORS) address bits) holds `busy` for SECT_BYTES+ERASE_CYC+1 cycles. After that, every byte of S reads 0xFF and other sectors keep their data. During the erase, status bit 7 reads 0.
- R6: When a run ends, reads return array data again and bit 6 no longer changes between reads.
- R7: A program or erase aimed at a sector whose `prot` bit is 1 never raises `busy` and leaves the data unchanged.
- R8: Writing 0xB0 during an erase drops `busy`. It then lets other sectors be read and returns status (bit 7 = 0, bit 6 toggling) for the sector being erased. Writing 0x30 resumes the erase, which completes with the sector at 0xFF.
- R9: While `lowvcc` is high, every bus write is ignored.
- R10: A first write other than 0x40 or 0x20, an erase confirm other than 0xD0, and any write during a program are ignored. The block then stays ready for the next command.
- R11: `standby` is high exactly when `ce_n` is high and no run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data / command byte |
| lowvcc | input | 1 | Low-supply write inhibit |
| prot | input | SECTORS | Per-sector protect mask |
| dout | output | 8 | Read data or status byte |
| dout_oe | output | 1 | High when the block drives `dout` |
| busy | output | 1 | Program or erase in progress |
| standby | output | 1 | Deselected and idle |

## Verification
The bench targets several corner cases. The first is programming a byte over an earlier programmed byte; a design that overwrote instead of ANDing would bring back set bits. The second is status reads during a run; a design that toggled bit 6 per clock rather than per read, or kept toggling after completion, would show equal or changing bits where the opposite is expected. Protected sectors, an erase confirm that is not 0xD0, and writes while `lowvcc` is high are all sent; a design that leaked any of them would show `busy` or altered bytes. The bench also parks an erase midway and resumes it. A design that kept counting while parked, or that served array data from the sector being erased, would disagree with the per-clock model on `busy` length or read value.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PSET,
    ST_ESET,
    ST_PROG,
    ST_PVER,
    ST_ERASE,
    ST_EVER,
    ST_SUSP
  } fst_t;

  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

endpackage

// File: rtl/flash_emu_bus.sv
module flash_emu_bus (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_stb,
  output logic rd_stb,
  output logic rd_act
);

  logic wr_act;
  logic wr_q;
  logic rd_q;

  always_comb begin
    wr_act = ~ce_n & ~we_n;
    rd_act = ~ce_n & ~oe_n & we_n;
    wr_stb = wr_act & ~wr_q;
    rd_stb = rd_act & ~rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

endmodule

// File: rtl/flash_emu_seq.sv
module flash_emu_seq
  import flash_emu_pkg::*;
#(
  parameter int AW         = 6,
  parameter int SECTORS    = 4,
  parameter int PROG_CYC   = 8,
  parameter int ERASE_CYC  = 20,
  localparam int SW        = $clog2(SECTORS),
  localparam int LW        = AW - SW,
  localparam int SECT_BYTES = 1 << LW,
  localparam int CNT_MAX   = (PROG_CYC > SECT_BYTES + ERASE_CYC) ? PROG_CYC : SECT_BYTES + ERASE_CYC,
  localparam int CW        = $clog2(CNT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         din,
  input  logic               lowvcc,
  input  logic [SECTORS-1:0] prot,
  output fst_t               st,
  output logic [7:0]         pd,
  output logic [SW-1:0]      esec,
  output logic               op_prog,
  output logic               op_zero,
  output logic               op_erase,
  output logic [AW-1:0]      op_addr
);

  fst_t          st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [AW-1:0] pa, pa_n;
  logic [7:0]    pd_n;
  logic [SW-1:0] esec_n;
  logic          cmd_ok;
  logic [SW-1:0] wsec;

  always_comb begin
    cmd_ok   = wr_stb & ~lowvcc;
    wsec     = addr[AW-1 -: SW];
    st_n     = st;
    cnt_n    = cnt;
    pa_n     = pa;
    pd_n     = pd;
    esec_n   = esec;
    op_prog  = 1'b0;
    op_zero  = 1'b0;
    op_erase = 1'b0;
    op_addr  = pa;
    case (st)
      ST_IDLE: if (cmd_ok) begin
        if (din == CMD_PROG)       st_n = ST_PSET;
        else if (din == CMD_ERASE) st_n = ST_ESET;
      end
      ST_PSET: if (cmd_ok) begin
        if (prot[wsec]) st_n = ST_IDLE;
        else begin
          st_n  = ST_PROG;
          pa_n  = addr;
          pd_n  = din;
          cnt_n = '0;
        end
      end
      ST_ESET: if (cmd_ok) begin
        if (din == CMD_CONFIRM && !prot[wsec]) begin
          st_n   = ST_ERASE;
          esec_n = wsec;
          cnt_n  = '0;
        end else st_n = ST_IDLE;
      end
      ST_PROG: begin
        if (cnt == CW'(PROG_CYC - 1)) begin
          op_prog = 1'b1;
          st_n    = ST_PVER;
        end else cnt_n = cnt + CW'(1);
      end
      ST_ERASE: begin
        if (cmd_ok && din == CMD_SUSPEND) st_n = ST_SUSP;
        else begin
          if (cnt < CW'(SECT_BYTES)) begin
            op_zero = 1'b1;
            op_addr = {esec, cnt[LW-1:0]};
          end
          if (cnt == CW'(SECT_BYTES + ERASE_CYC - 1)) begin
            op_erase = 1'b1;
            st_n     = ST_EVER;
          end else cnt_n = cnt + CW'(1);
        end
      end
      ST_SUSP: if (cmd_ok && din == CMD_RESUME) st_n = ST_ERASE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      pa   <= '0;
      pd   <= '0;
      esec <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      pa   <= pa_n;
      pd   <= pd_n;
      esec <= esec_n;
    end
  end

endmodule

// File: rtl/flash_emu_store.sv
module flash_emu_store #(
  parameter int DEPTH   = 64,
  parameter int SECTORS = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int SW     = $clog2(SECTORS),
  localparam int SECT_BYTES = DEPTH / SECTORS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_prog,
  input  logic          op_zero,
  input  logic          op_erase,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  input  logic [SW-1:0] esec,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  assign rdata = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (op_erase && esec == SW'(i / SECT_BYTES))
          mem[i] <= 8'hFF;
        else if (op_prog && op_addr == AW'(i))
          mem[i] <= mem[i] & op_data;
        else if (op_zero && op_addr == AW'(i))
          mem[i] <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_emu.sv
module flash_cmd_emu
  import flash_emu_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int SECTORS   = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20,
  localparam int AW       = $clog2(DEPTH),
  localparam int SW       = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         din,
  input  logic               lowvcc,
  input  logic [SECTORS-1:0] prot,
  output logic [7:0]         dout,
  output logic               dout_oe,
  output logic               busy,
  output logic               standby
);

  logic [1:0]    rst_q;
  logic          arst_n;
  logic          wr_stb, rd_stb, rd_act;
  fst_t          st;
  logic [7:0]    pd;
  logic [SW-1:0] esec;
  logic          op_prog, op_zero, op_erase;
  logic [AW-1:0] op_addr;
  logic [7:0]    rdata;
  logic          tog, tog_n;
  logic          stat_sel;
  logic [7:0]    stat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign arst_n = rst_q[1];

  flash_emu_bus u_bus (
    .clk(clk), .rst_n(arst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_act(rd_act)
  );

  flash_emu_seq #(
    .AW(AW), .SECTORS(SECTORS), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(arst_n), .wr_stb(wr_stb), .addr(addr), .din(din),
    .lowvcc(lowvcc), .prot(prot), .st(st), .pd(pd), .esec(esec),
    .op_prog(op_prog), .op_zero(op_zero), .op_erase(op_erase), .op_addr(op_addr)
  );

  flash_emu_store #(.DEPTH(DEPTH), .SECTORS(SECTORS)) u_store (
    .clk(clk), .rst_n(arst_n), .op_prog(op_prog), .op_zero(op_zero),
    .op_erase(op_erase), .op_addr(op_addr), .op_data(pd), .esec(esec),
    .raddr(addr), .rdata(rdata)
  );

  always_comb begin
    busy      = (st == ST_PROG) || (st == ST_PVER) || (st == ST_ERASE) || (st == ST_EVER);
    stat_sel  = busy || (st == ST_SUSP && addr[AW-1 -: SW] == esec);
    stat_byte = {((st == ST_PROG) || (st == ST_PVER)) ? ~pd[7] : 1'b0, tog, 6'b000000};
    tog_n     = tog ^ (rd_stb & stat_sel);
    dout_oe   = rd_act;
    dout      = rd_act ? (stat_sel ? stat_byte : rdata) : 8'h00;
    standby   = ce_n & ~busy;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) tog <= 1'b0;
    else         tog <= tog_n;
  end

endmodule

// File: rtl/flash_emu_chk.sv
module flash_emu_chk
  import flash_emu_pkg::*;
#(
  parameter int AW      = 6,
  parameter int SECTORS = 4,
  localparam int SW     = $clog2(SECTORS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      addr,
  input logic [7:0]         din,
  input logic               lowvcc,
  input logic [SECTORS-1:0] prot,
  input logic [7:0]         dout,
  input logic               dout_oe,
  input logic               busy,
  input fst_t               st,
  input logic [7:0]         pd,
  input logic               wr_stb,
  input logic               rd_stb,
  input logic               tog
);

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == 8'h00);

  assert_toggle_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb) |=> tog != $past(tog));

  assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && (st == ST_PROG || st == ST_PVER)) |-> dout[7] == ~pd[7]);

  assert_back_to_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PVER || st == ST_EVER) |=> (st == ST_IDLE && !busy));

  assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PSET && wr_stb && !lowvcc && prot[addr[AW-1 -: SW]]) |=> !busy);

  assert_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERASE && wr_stb && !lowvcc && din == CMD_SUSPEND) |=> (!busy && st == ST_SUSP));

  assert_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lowvcc && !busy) |=> !busy);

endmodule

bind flash_cmd_emu flash_emu_chk #(.AW(AW), .SECTORS(SECTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .lowvcc(lowvcc),
  .prot(prot), .dout(dout), .dout_oe(dout_oe), .busy(busy), .st(st),
  .pd(pd), .wr_stb(wr_stb), .rd_stb(rd_stb), .tog(tog)
);

// File: tb/sim_flash_cmd_emu.sv
module sim_flash_cmd_emu;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int SECTORS    = 4;
  localparam int PROG_CYC   = 8;
  localparam int ERASE_CYC  = 20;
  localparam int AW         = $clog2(DEPTH);
  localparam int SB         = DEPTH / SECTORS;

  logic clk, rst_n, ce_n, we_n, oe_n, lowvcc;
  logic [AW-1:0] addr;
  logic [7:0] din, dout;
  logic [SECTORS-1:0] prot;
  logic dout_oe, busy, standby;

  int n_chk = 0;
  int n_fail = 0;

  flash_cmd_emu #(.DEPTH(DEPTH), .SECTORS(SECTORS), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .din(din), .lowvcc(lowvcc), .prot(prot), .dout(dout), .dout_oe(dout_oe),
    .busy(busy), .standby(standby)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: 0 idle, 1 program setup, 2 erase setup, 3 programming, 4 erasing, 5 parked
  int m_mode, m_left, m_pa, m_esec, m_sec;
  logic [7:0] m_pd;
  logic [7:0] m_mem [DEPTH];
  bit m_wprev, m_rprev, m_tog, m_wact, m_ract, m_ok;

  function automatic bit m_busy();
    return m_mode == 3 || m_mode == 4;
  endfunction

  function automatic bit m_stat(input int a);
    return m_busy() || (m_mode == 5 && a / SB == m_esec);
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    if (m_stat(a)) return {(m_mode == 3) ? ~m_pd[7] : 1'b0, m_tog, 6'b0};
    return m_mem[a];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_pa = 0; m_pd = 0; m_esec = 0;
      m_wprev = 0; m_rprev = 0; m_tog = 0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    end else begin
      m_wact = !ce_n && !we_n;
      m_ract = !ce_n && !oe_n && we_n;
      m_ok   = m_wact && !m_wprev && !lowvcc;
      m_sec  = int'(addr) / SB;
      if (m_ract && !m_rprev && m_stat(int'(addr))) m_tog = !m_tog;
      case (m_mode)
        0: if (m_ok) begin
          if (din == 8'h40) m_mode = 1;
          else if (din == 8'h20) m_mode = 2;
        end
        1: if (m_ok) begin
          if (prot[m_sec]) m_mode = 0;
          else begin m_pa = int'(addr); m_pd = din; m_left = PROG_CYC + 1; m_mode = 3; end
        end
        2: if (m_ok) begin
          if (din == 8'hD0 && !prot[m_sec]) begin m_esec = m_sec; m_left = SB + ERASE_CYC + 1; m_mode = 4; end
          else m_mode = 0;
        end
        3: begin
          m_left--;
          if (m_left == 1) m_mem[m_pa] = m_mem[m_pa] & m_pd;
          if (m_left == 0) m_mode = 0;
        end
        4: begin
          if (m_ok && din == 8'hB0) m_mode = 5;
          else begin
            m_left--;
            if (m_left == 1) for (int i = 0; i < SB; i++) m_mem[m_esec * SB + i] = 8'hFF;
            if (m_left == 0) m_mode = 0;
          end
        end
        5: if (m_ok && din == 8'h30) m_mode = 4;
        default: m_mode = 0;
      endcase
      m_wprev = m_wact;
      m_rprev = m_ract;
    end
  end

  // Per-clock comparison of busy and standby against the model
  int run = 0;
  int last_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == m_busy(), "R5", "busy vs model", busy, m_busy());
      check(standby == (ce_n && !m_busy()), "R11", "standby vs model", standby, ce_n && !m_busy());
      if (busy) run++;
      else if (run > 0) begin last_run = run; run = 0; end
    end
  end

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input int a, input string req, output logic [7:0] v);
    logic [7:0] e;
    @(negedge clk);
    addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
    #1;
    e = exp_read(a);
    v = dout;
    check(dout_oe == 1'b1, req, "read drive", dout_oe, 1);
    check(dout == e, req, "read value", dout, e);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 2000) begin @(negedge clk); g++; end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v1, v2;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lowvcc = 1'b0;
    addr = '0; din = '0; prot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(dout_oe == 1'b0, "R1", "drive after reset", dout_oe, 0);
    check(standby == 1'b1, "R11", "standby when deselected", standby, 1);
    rd(5, "R1", v1);
    check(v1 == 8'hFF, "R1", "erased content", v1, 8'hFF);

    // R2 no drive while write strobe low or chip deselected
    @(negedge clk);
    din = 8'h00; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    #1;
    check(dout_oe == 1'b0 && dout == 8'h00, "R2", "drive with we_n low", dout, 0);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    #1;
    check(dout_oe == 1'b0 && dout == 8'h00, "R2", "drive with ce_n high", dout, 0);
    @(negedge clk);
    oe_n = 1'b1;

    // R3 R4 program with status polling
    wr(0, 8'h40);
    wr(5, 8'h3C);
    #1;
    check(standby == 1'b0, "R11", "no standby while busy", standby, 0);
    rd(5, "R4", v1);
    rd(5, "R4", v2);
    check(v1[7] == 1'b1, "R4", "poll bit7", v1[7], 1);
    check(v1[6] != v2[6], "R4", "toggle bit6", v2[6], !v1[6]);
    wait_idle();
    check(last_run == PROG_CYC + 1, "R3", "program busy length", last_run, PROG_CYC + 1);
    rd(5, "R3", v1);
    rd(5, "R6", v2);
    check(v1 == 8'h3C, "R3", "programmed byte", v1, 8'h3C);
    check(v1 == v2, "R6", "toggle stopped", v2, v1);

    // R3 AND behaviour
    wr(0, 8'h40);
    wr(5, 8'hF0);
    wait_idle();
    rd(5, "R3", v1);
    check(v1 == 8'h30, "R3", "AND on reprogram", v1, 8'h30);

    // R4 poll bit with data bit7 set
    wr(0, 8'h40);
    wr(6, 8'h81);
    rd(6, "R4", v1);
    check(v1[7] == 1'b0, "R4", "poll bit7 complement", v1[7], 0);
    wait_idle();
    wr(0, 8'h40);
    wr(40, 8'h55);
    wait_idle();
    wr(0, 8'h40);
    wr(50, 8'h0F);
    wait_idle();

    // R7 protected sector
    prot = 4'b0010;
    wr(0, 8'h40);
    wr(20, 8'h00);
    #1;
    check(busy == 1'b0, "R7", "protected program", busy, 0);
    wr(0, 8'h20);
    wr(16, 8'hD0);
    #1;
    check(busy == 1'b0, "R7", "protected erase", busy, 0);
    rd(20, "R7", v1);
    check(v1 == 8'hFF, "R7", "protected data", v1, 8'hFF);
    prot = '0;

    // R5 erase of sector 0
    wr(0, 8'h20);
    wr(3, 8'hD0);
    rd(5, "R5", v1);
    check(v1[7] == 1'b0, "R5", "erase poll bit7", v1[7], 0);
    wait_idle();
    check(last_run == SB + ERASE_CYC + 1, "R5", "erase busy length", last_run, SB + ERASE_CYC + 1);
    rd(5, "R5", v1);
    check(v1 == 8'hFF, "R5", "erased byte 5", v1, 8'hFF);
    rd(6, "R5", v1);
    check(v1 == 8'hFF, "R5", "erased byte 6", v1, 8'hFF);
    rd(40, "R5", v1);
    check(v1 == 8'h55, "R5", "other sector kept", v1, 8'h55);

    // R8 park and resume an erase of sector 2
    wr(0, 8'h20);
    wr(40, 8'hD0);
    repeat (5) @(negedge clk);
    wr(0, 8'hB0);
    #1;
    check(busy == 1'b0, "R8", "busy while parked", busy, 0);
    rd(50, "R8", v1);
    check(v1 == 8'h0F, "R8", "read other sector", v1, 8'h0F);
    rd(40, "R8", v1);
    rd(41, "R8", v2);
    check(v1[7] == 1'b0 && v1[6] != v2[6], "R8", "status in erasing sector", v2, {1'b0, !v1[6], 6'b0});
    wr(0, 8'h30);
    #1;
    check(busy == 1'b1, "R8", "busy after resume", busy, 1);
    wait_idle();
    rd(40, "R8", v1);
    check(v1 == 8'hFF, "R8", "erase completed", v1, 8'hFF);

    // R9 low-supply inhibit
    lowvcc = 1'b1;
    wr(0, 8'h40);
    wr(60, 8'h00);
    #1;
    check(busy == 1'b0, "R9", "inhibited program", busy, 0);
    lowvcc = 1'b0;
    rd(60, "R9", v1);
    check(v1 == 8'hFF, "R9", "inhibited data", v1, 8'hFF);

    // R10 ignored writes
    wr(0, 8'h77);
    wr(7, 8'h00);
    rd(7, "R10", v1);
    check(v1 == 8'hFF, "R10", "unknown command", v1, 8'hFF);
    wr(0, 8'h20);
    wr(0, 8'h11);
    #1;
    check(busy == 1'b0, "R10", "bad erase confirm", busy, 0);
    wr(0, 8'h40);
    wr(9, 8'h5A);
    wait_idle();
    rd(9, "R10", v1);
    check(v1 == 8'h5A, "R10", "ready after abort", v1, 8'h5A);
    wr(0, 8'h40);
    wr(8, 8'hAA);
    wr(8, 8'h00);
    wait_idle();
    rd(8, "R10", v1);
    check(v1 == 8'hAA, "R10", "write during program", v1, 8'hAA);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule